// File: doc/BRIEF.md
# Vectored Prioritized Interrupt Controller

This block collects one-cycle event pulses from 18 interrupt sources and chooses which one an 8-bit CPU core services next. It hands the core a vector address. Each source has a sticky pending flag and an enable bit, and a global enable gates all of them. The sources share priority in six groups: group g holds sources g, g+6 and g+12. Each group takes a two-bit level, with its high bit from one priority register and its low bit from another.

The block hands a vector over a valid/ready stream. When at least one admissible request is pending, the block latches the winner and raises `irq_valid` with the vector. It holds both unchanged until the core accepts them with `irq_ready`. Back-pressure is unlimited: `irq_valid` and `irq_vec` do not change while `irq_ready` is low. `irq_ready` has no effect while `irq_valid` is low.

Each accepted vector pushes the winner's level onto an in-service stack. A `reti` strobe pops that stack. A pending request is admitted only when its level is strictly above the top of that stack, so handlers nest by level.

Top module: `irq_vector_ctrl`

## Requirements
- R1: A one-cycle pulse on `src_pulse[n]` sets `irq_flags[n]` at the next clock edge. The flag stays set until it is cleared.
- R2: `sw_clr[n]` clears `irq_flags[n]` at the next edge. If a set and a clear hit the same cycle, the flag stays set.
- R3: A source can win only when its flag, `src_en[n]` and `glob_en` are all 1. With `glob_en` low, `irq_valid` stays 0.
- R4: The level of source n is `{prio_hi[n mod 6], prio_lo[n mod 6]}`, where 3 is the highest. The admissible source with the highest level wins.
- R5: Among admissible sources at the winning level, the lowest source number wins.
- R6: `irq_vec` equals 0x03 + 8·n for winning source n, so source 0 gives 0x03 and source 17 gives 0x8B.
- R7: The request takes one cycle to detect. A flag set at edge k raises `irq_valid` after edge k+1. `irq_valid` and `irq_vec` stay stable until `irq_valid && irq_ready`, and later pulses do not change them.
- R8: On acceptance, the winner's flag is cleared if `auto_clr[n]` is 1, and kept if it is 0.
- R9: While a level is in service, only a request with a strictly higher level raises `irq_valid`. A request at an equal or lower level waits.
- R10: A `reti` pulse pops the newest in-service level. Requests blocked by that level become admissible on the next edge.
- R11: After reset, all flags are 0, `irq_valid` is 0 and no level is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 18 | One-cycle event pulses, one per source |
| sw_clr | input | 18 | Software flag clear, one per source |
| auto_clr | input | 18 | Clear the flag on acceptance, one per source |
| src_en | input | 18 | Per-source enable |
| glob_en | input | 1 | Global enable |
| prio_lo | input | 6 | Low bit of each group's level |
| prio_hi | input | 6 | High bit of each group's level |
| irq_valid | output | 1 | A vector is offered to the core |
| irq_ready | input | 1 | Core accepts the offered vector |
| irq_vec | output | 8 | Vector address of the offered source |
| reti | input | 1 | Return-from-interrupt strobe |
| irq_flags | output | 18 | Pending flags, readable |

## Verification
On every cycle, the assertions check the following properties:
- a pulse always lands in its flag, and a clear without a set always empties it;
- an offered vector stays stable under back-pressure;
- every vector lies on the 8-byte grid;
- a latched winner is flagged and enabled;
- an accepted auto-clear source loses its flag;
- the in-service stack never overflows and only grows with strictly rising levels.

Only the bench scenarios can show which source wins for given priority settings and tie patterns, and the exact detection latency. The same holds for blocking an equal-level request until `reti`, and for keeping a flag whose auto-clear bit is off.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DEF_NSRC = 18;
  localparam int unsigned DEF_NGRP = 6;
  localparam int unsigned LVL_W    = 2;

  typedef enum logic {
    DLV_IDLE  = 1'b0,
    DLV_OFFER = 1'b1
  } dlv_e;
endpackage

// File: rtl/irqc_flags.sv
module irqc_flags #(
  parameter int unsigned NSRC = irqc_pkg::DEF_NSRC
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] flag_o
);
  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    logic q;
    // set dominates clear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= set_i[i] | (q & ~clr_i[i]);
    end
    assign flag_o[i] = q;

    assert_pulse_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned NSRC = irqc_pkg::DEF_NSRC,
  parameter int unsigned NGRP = irqc_pkg::DEF_NGRP,
  localparam int unsigned IDW = $clog2(NSRC),
  localparam int unsigned LW  = irqc_pkg::LVL_W
) (
  input  logic [NSRC-1:0] flag_i,
  input  logic [NSRC-1:0] en_i,
  input  logic            glob_en_i,
  input  logic [NGRP-1:0] prio_lo_i,
  input  logic [NGRP-1:0] prio_hi_i,
  input  logic            cur_valid_i,
  input  logic [LW-1:0]   cur_lvl_i,
  output logic            hit_o,
  output logic [IDW-1:0]  win_id_o,
  output logic [LW-1:0]   win_lvl_o
);
  logic [LW-1:0]   src_lvl [NSRC];
  logic [NSRC-1:0] cand;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    assign src_lvl[n] = {prio_hi_i[n % NGRP], prio_lo_i[n % NGRP]};
    assign cand[n]    = flag_i[n] & en_i[n] & glob_en_i &
                        (!cur_valid_i || (src_lvl[n] > cur_lvl_i));
  end

  // downward scan with >= lets the lowest index win a tie
  always_comb begin
    hit_o     = 1'b0;
    win_id_o  = '0;
    win_lvl_o = '0;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (cand[n] && (!hit_o || (src_lvl[n] >= win_lvl_o))) begin
        hit_o     = 1'b1;
        win_id_o  = IDW'(n);
        win_lvl_o = src_lvl[n];
      end
    end
  end
endmodule

// File: rtl/irqc_nest_stack.sv
module irqc_nest_stack #(
  localparam int unsigned LW    = irqc_pkg::LVL_W,
  localparam int unsigned DEPTH = 1 << LW,
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [LW-1:0] push_lvl_i,
  input  logic          pop_i,
  output logic          top_valid_o,
  output logic [LW-1:0] top_lvl_o
);
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] lvl_mem [DEPTH];
  logic          pop_eff;
  logic [CW-1:0] wr_ptr;
  logic [LW-1:0] rd_ptr;

  assign pop_eff     = pop_i && (cnt_q != '0);
  assign wr_ptr      = cnt_q - CW'(pop_eff);
  assign rd_ptr      = LW'(cnt_q - CW'(1));
  assign top_valid_o = (cnt_q != '0);
  assign top_lvl_o   = lvl_mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_q - CW'(pop_eff) + CW'(push_i);
  end

  always_ff @(posedge clk) begin
    if (push_i) lvl_mem[LW'(wr_ptr)] <= push_lvl_i;
  end

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (wr_ptr < CW'(DEPTH)));
  assert_rising_nest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && top_valid_o && !pop_i) |-> (push_lvl_i > top_lvl_o));
  assert_pop_shrinks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && top_valid_o && !push_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter int unsigned NSRC       = irqc_pkg::DEF_NSRC,
  parameter int unsigned NGRP       = irqc_pkg::DEF_NGRP,
  parameter int unsigned VW         = 8,
  parameter int unsigned VEC_BASE   = 3,
  parameter int unsigned VEC_STRIDE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pulse,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] auto_clr,
  input  logic [NSRC-1:0] src_en,
  input  logic            glob_en,
  input  logic [NGRP-1:0] prio_lo,
  input  logic [NGRP-1:0] prio_hi,
  output logic            irq_valid,
  input  logic            irq_ready,
  output logic [VW-1:0]   irq_vec,
  input  logic            reti,
  output logic [NSRC-1:0] irq_flags
);
  import irqc_pkg::*;
  localparam int unsigned IDW = $clog2(NSRC);
  localparam int unsigned LW  = LVL_W;

  dlv_e            dlv_q;
  logic [IDW-1:0]  id_q;
  logic [LW-1:0]   lvl_q;
  logic [VW-1:0]   vec_q;
  logic            hit;
  logic [IDW-1:0]  win_id;
  logic [LW-1:0]   win_lvl;
  logic            top_valid;
  logic [LW-1:0]   top_lvl;
  logic            ack;
  logic [NSRC-1:0] ack_mask;
  logic [NSRC-1:0] clr_all;
  logic [VW-1:0]   vec_d;

  assign ack      = (dlv_q == DLV_OFFER) && irq_ready;
  assign ack_mask = ack ? ((NSRC'(1) << id_q) & auto_clr) : '0;
  assign clr_all  = sw_clr | ack_mask;
  assign vec_d    = VW'(VEC_BASE) + VW'(VEC_STRIDE) * VW'(win_id);

  irqc_flags #(.NSRC(NSRC)) i_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (src_pulse),
    .clr_i  (clr_all),
    .flag_o (irq_flags)
  );

  irqc_arbiter #(.NSRC(NSRC), .NGRP(NGRP)) i_arb (
    .flag_i      (irq_flags),
    .en_i        (src_en),
    .glob_en_i   (glob_en),
    .prio_lo_i   (prio_lo),
    .prio_hi_i   (prio_hi),
    .cur_valid_i (top_valid),
    .cur_lvl_i   (top_lvl),
    .hit_o       (hit),
    .win_id_o    (win_id),
    .win_lvl_o   (win_lvl)
  );

  irqc_nest_stack i_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (ack),
    .push_lvl_i  (lvl_q),
    .pop_i       (reti),
    .top_valid_o (top_valid),
    .top_lvl_o   (top_lvl)
  );

  // detect cycle: winner latched here, offered until accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dlv_q <= DLV_IDLE;
      id_q  <= '0;
      lvl_q <= '0;
      vec_q <= '0;
    end else begin
      case (dlv_q)
        DLV_IDLE: if (hit) begin
          dlv_q <= DLV_OFFER;
          id_q  <= win_id;
          lvl_q <= win_lvl;
          vec_q <= vec_d;
        end
        DLV_OFFER: if (irq_ready) dlv_q <= DLV_IDLE;
        default: dlv_q <= DLV_IDLE;
      endcase
    end
  end

  assign irq_valid = (dlv_q == DLV_OFFER);
  assign irq_vec   = vec_q;

  assert_offer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ready) |=> (irq_valid && $stable(irq_vec)));
  assert_vec_grid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> ((((irq_vec - VW'(VEC_BASE)) % VW'(VEC_STRIDE)) == '0) &&
                   (irq_vec <= VW'(VEC_BASE + VEC_STRIDE * (NSRC - 1)))));
  assert_winner_eligible_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_valid && hit) |-> (irq_flags[win_id] && src_en[win_id] && glob_en));
  assert_auto_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ((ack_mask & src_pulse) == '0)) |=> ((irq_flags & $past(ack_mask)) == '0));
endmodule

// File: tb/test_irq_vector_ctrl.sv
module test_irq_vector_ctrl;
  localparam int N = 18;
  localparam int G = 6;

  typedef struct packed {
    logic [N-1:0] en;
    logic [G-1:0] lo;
    logic [G-1:0] hi;
    logic [N-1:0] pulse;
    logic [4:0]   id;
  } row_t;

  // table: enables, level bits, pulsed sources, expected winner
  localparam row_t TBL [6] = '{
    '{en: '1, lo: 6'h00, hi: 6'h00, pulse: 18'h00001, id: 5'd0},
    '{en: '1, lo: 6'h00, hi: 6'h00, pulse: 18'h20000, id: 5'd17},
    '{en: '1, lo: 6'h00, hi: 6'h00, pulse: 18'h00820, id: 5'd5},
    '{en: '1, lo: 6'h08, hi: 6'h08, pulse: 18'h00204, id: 5'd9},
    '{en: '1, lo: 6'h01, hi: 6'h04, pulse: 18'h04001, id: 5'd14},
    '{en: 18'h3FFF7, lo: 6'h00, hi: 6'h00, pulse: 18'h00088, id: 5'd7}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] src_pulse = '0, sw_clr = '0, auto_clr = '1, src_en = '1;
  logic         glob_en = 1'b0;
  logic [G-1:0] prio_lo = '0, prio_hi = '0;
  logic         irq_ready = 1'b0, reti = 1'b0;
  logic         irq_valid;
  logic [7:0]   irq_vec;
  logic [N-1:0] irq_flags;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  irq_vector_ctrl i_irq_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .sw_clr(sw_clr),
    .auto_clr(auto_clr), .src_en(src_en), .glob_en(glob_en),
    .prio_lo(prio_lo), .prio_hi(prio_hi), .irq_valid(irq_valid),
    .irq_ready(irq_ready), .irq_vec(irq_vec), .reti(reti),
    .irq_flags(irq_flags)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_of(input int id);
    return 32'(3 + 8 * id);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R11 reset state
    check("R11 flags", 32'(irq_flags), 0);
    check("R11 valid", 32'(irq_valid), 0);
    rst_n = 1'b1;
    tick();
    check("R11 valid after release", 32'(irq_valid), 0);

    foreach (TBL[r]) begin
      src_en    = TBL[r].en;
      prio_lo   = TBL[r].lo;
      prio_hi   = TBL[r].hi;
      glob_en   = 1'b1;
      auto_clr  = '1;
      src_pulse = TBL[r].pulse;
      tick();
      src_pulse = '0;
      check("R1 flags after pulse", 32'(irq_flags), 32'(TBL[r].pulse));
      check("R7 valid low in detect cycle", 32'(irq_valid), 0);
      tick();
      check("R7 valid raised", 32'(irq_valid), 1);
      check("R4 R5 R6 winner vector", 32'(irq_vec), vec_of(int'(TBL[r].id)));
      irq_ready = 1'b1;
      tick();
      irq_ready = 1'b0;
      check("R8 winner flag auto cleared", 32'(irq_flags[TBL[r].id]), 0);
      reti   = 1'b1;
      sw_clr = '1;
      tick();
      reti   = 1'b0;
      sw_clr = '0;
      tick();
      check("R10 idle after cleanup", 32'(irq_valid), 0);
    end

    // R2 set/clear interplay, requests blocked by global enable
    glob_en = 1'b0;
    src_en  = '1;
    prio_lo = '0;
    prio_hi = '0;
    src_pulse[4] = 1'b1;
    tick();
    src_pulse = '0;
    check("R1 flag4 set", 32'(irq_flags[4]), 1);
    src_pulse[4] = 1'b1;
    sw_clr[4]    = 1'b1;
    tick();
    src_pulse = '0;
    sw_clr    = '0;
    check("R2 set beats clear", 32'(irq_flags[4]), 1);
    sw_clr[4] = 1'b1;
    tick();
    sw_clr = '0;
    check("R2 clear alone", 32'(irq_flags[4]), 0);

    // R3 global enable gate
    prio_lo[1] = 1'b1;
    prio_hi[1] = 1'b1;
    src_pulse[6] = 1'b1;
    tick();
    src_pulse = '0;
    tick();
    tick();
    check("R3 no request with global enable low", 32'(irq_valid), 0);
    glob_en = 1'b1;
    tick();
    check("R3 request after global enable", 32'(irq_valid), 1);
    check("R6 vector source 6", 32'(irq_vec), vec_of(6));

    // R7 hold under back-pressure while a higher level arrives
    src_pulse[7] = 1'b1;
    tick();
    src_pulse = '0;
    tick();
    tick();
    check("R7 valid held", 32'(irq_valid), 1);
    check("R7 vector held", 32'(irq_vec), vec_of(6));
    irq_ready = 1'b1;
    tick();
    irq_ready = 1'b0;
    check("R7 valid drops on accept", 32'(irq_valid), 0);
    tick();
    check("R9 higher level preempts", 32'(irq_vec), vec_of(7));
    check("R9 preempt valid", 32'(irq_valid), 1);
    irq_ready = 1'b1;
    tick();
    irq_ready = 1'b0;

    // R9 equal level blocked, R10 released by reti, R8 kept flag
    auto_clr[13] = 1'b0;
    src_pulse[13] = 1'b1;
    tick();
    src_pulse = '0;
    tick();
    tick();
    check("R9 equal level waits", 32'(irq_valid), 0);
    check("R9 blocked flag pending", 32'(irq_flags[13]), 1);
    reti = 1'b1;
    tick();
    reti = 1'b0;
    tick();
    check("R10 request after pop", 32'(irq_valid), 1);
    check("R10 vector source 13", 32'(irq_vec), vec_of(13));
    irq_ready = 1'b1;
    tick();
    irq_ready = 1'b0;
    check("R8 flag kept without auto clear", 32'(irq_flags[13]), 1);
    reti   = 1'b1;
    sw_clr = '1;
    tick();
    sw_clr = '0;
    tick();
    reti = 1'b0;
    tick();
    tick();
    check("R10 idle after final pops", 32'(irq_valid), 0);
    check("R2 flags cleared", 32'(irq_flags), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule